// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Bank

This block manages sixteen general-purpose pins through a small word-addressed register bus. Each pin is an input or an output. An output pin drives one of three stored levels: the normal level, a sleep level, or a battery-fault level. The level used depends on which power state the rest of the chip signals. Input levels pass through a two-flop synchroniser. The synchronised levels can be read back, and each pin watches them for its own trigger condition.

Each pin chooses its trigger separately: a level (low or high) or an edge (falling or rising). When a pin's trigger condition occurs, its interrupt-status bit is set. Software clears a status bit by writing 1 to it. One interrupt line combines every status bit that its mask allows through, and in sleep mode a second mask also gates it. A per-pin select register is brought out so that neighbouring logic can hand a pin to another function.

Top module: `gpio_irq_bank`

## Requirements
- R1: While `rstN` is low, every register reads 0, `pinOe`, `pinOut`, `altSel` and `irqOut` are 0, and the pin-status register reads 0. The synchroniser stages reset low, so the default low-level trigger may flag pins during the first cycles after release.
- R2: Registers sit at byte offsets and are 16 bits wide. The read/write registers are: 0x00 interrupt mask, 0x04 direction, 0x08 normal output, 0x0C trigger select, 0x10 edge polarity, 0x14 level polarity, 0x18 sleep interrupt mask, 0x1C sleep output, 0x20 battery-fault output, 0x28 function select and 0x2C sleep configuration. Each reads back the last value written to it, and the read data is combinational from the address. Addresses with bits [1:0] non-zero, and offsets above 0x30, read 0 and ignore writes.
- R3: Offset 0x30 is read-only. It returns the input pins after two flops, so an input change shows there after the second rising clock edge. Writes to it have no effect.
- R4: `pinOe` equals the direction register (1 = output). In normal mode `pinOut` equals the normal output register.
- R5: When `sleepMode` is 1 and `battFault` is 0, `pinOut` equals the sleep output register.
- R6: When `battFault` is 1, `pinOut` equals the battery-fault output register, whether or not `sleepMode` is set.
- R7: A trigger-select bit of 0 selects level detection: level-polarity bit 0 detects low, and 1 detects high. The status bit sets one edge after the synchronised level matches. It sets again after a clear for as long as the level persists.
- R8: A trigger-select bit of 1 selects edge detection: edge-polarity bit 1 detects a rising edge, and 0 detects a falling edge. An edge of the other direction does not set the bit. The bit stays set until cleared and does not set again while the pin holds still.
- R9: The interrupt status register at 0x24 is write-1-to-clear: a 1 clears that bit and a 0 leaves it. If a trigger occurs in the same cycle as a clear of that bit, the bit stays set.
- R10: `irqOut` is the OR of every status bit whose interrupt-mask bit is 0. A mask bit of 1 blocks the pin from `irqOut` but does not stop its status bit from setting.
- R11: While `sleepMode` is 1, a sleep-mask bit of 1 also blocks that pin from `irqOut`. The sleep mask has no effect while `sleepMode` is 0.
- R12: `altSel` equals the function select register at 0x28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 6 | Byte address of the register access |
| regWe | input | 1 | Write strobe for the current address |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Read data for the current address |
| pinIn | input | 16 | Raw pin levels from the pads |
| pinOut | output | 16 | Level each pin drives when enabled |
| pinOe | output | 16 | Output enable per pin |
| altSel | output | 16 | Per-pin function select |
| sleepMode | input | 1 | Chip is in sleep state |
| battFault | input | 1 | Chip is in battery-fault state |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench targets the places where an interrupt bank usually goes wrong. A level trigger is cleared while its level is still present; a design that lets the clear win would drop a live request. A falling edge arrives on a pin armed for rising edges, which catches swapped polarity decoding. An edge bit is cleared while the pin holds still, so a design that treats edges as levels shows a re-armed bit. A sleep mask is applied with and without `sleepMode`, and both power states are asserted together, which exposes wrong gating or wrong priority. It also times the two-flop synchroniser edge by edge, and it writes zeros to the status register to catch a plain-write status.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  // Word index of each register; index = byte offset / 4.
  typedef enum logic [3:0] {
    REG_MASK   = 4'd0,
    REG_DIR    = 4'd1,
    REG_OUT    = 4'd2,
    REG_TRIG   = 4'd3,
    REG_EDGPOL = 4'd4,
    REG_LVLPOL = 4'd5,
    REG_SMASK  = 4'd6,
    REG_SOUT   = 4'd7,
    REG_BFOUT  = 4'd8,
    REG_STAT   = 4'd9,
    REG_ALT    = 4'd10,
    REG_SCONF  = 4'd11,
    REG_PSTAT  = 4'd12
  } regIdx_e;

  localparam int NUM_REGS = 13;

  // Strobes from the bus decoder to the datapath.
  typedef struct packed {
    logic [NUM_REGS-1:0] wrEn;
    regIdx_e             rdSel;
    logic                rdHit;
  } strobe_t;

endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output strobe_t           strb
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             inMap;

  assign wordIdx = regAddr[ADDR_W-1:2];
  assign aligned = (regAddr[1:0] == 2'b00);
  assign inMap   = aligned && (wordIdx < IDX_W'(NUM_REGS));

  always_comb begin
    strb.wrEn  = '0;
    strb.rdHit = inMap;
    strb.rdSel = inMap ? regIdx_e'(wordIdx[3:0]) : REG_MASK;
    if (regWe && inMap) begin
      strb.wrEn[wordIdx] = 1'b1;
    end
  end

  // R2: one decoded write strobe at most
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.wrEn));

endmodule

// File: rtl/gpio_bank_dp.sv
module gpio_bank_dp
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [PINS-1:0] regWdata,
  output logic [PINS-1:0] regRdata,
  input  logic [PINS-1:0] pinIn,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOe,
  output logic [PINS-1:0] altSel,
  input  logic            sleepMode,
  input  logic            battFault,
  output logic            irqOut
);

  logic [PINS-1:0] regs [NUM_REGS];
  logic [PINS-1:0] syncA, syncB, syncPrev;
  logic [PINS-1:0] trigHit;
  logic [PINS-1:0] status;
  logic [PINS-1:0] clrBits;
  logic [PINS-1:0] effMask;

  // Stored registers; status and pin level are views onto other state.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    if (r == int'(REG_STAT)) begin : g_stat
      always_comb regs[r] = status;
    end else if (r == int'(REG_PSTAT)) begin : g_pstat
      always_comb regs[r] = syncB;
    end else begin : g_rw
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regs[r] <= '0;
        end else if (strb.wrEn[r]) begin
          regs[r] <= regWdata;
        end
      end
    end
  end

  assign regRdata = strb.rdHit ? regs[strb.rdSel] : '0;

  // Two-flop synchroniser plus one history stage for edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= '0;
      syncB    <= '0;
      syncPrev <= '0;
    end else begin
      syncA    <= pinIn;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_det
    logic rise, fall, lvl;
    assign rise = syncB[i] & ~syncPrev[i];
    assign fall = ~syncB[i] & syncPrev[i];
    assign lvl  = regs[REG_LVLPOL][i] ? syncB[i] : ~syncB[i];
    assign trigHit[i] = regs[REG_TRIG][i]
                      ? (regs[REG_EDGPOL][i] ? rise : fall)
                      : lvl;
  end

  assign clrBits = strb.wrEn[REG_STAT] ? regWdata : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= '0;
    end else begin
      status <= (status & ~clrBits) | trigHit;
    end
  end

  assign effMask = regs[REG_MASK] | (sleepMode ? regs[REG_SMASK] : '0);
  assign irqOut  = |(status & ~effMask);

  assign pinOe  = regs[REG_DIR];
  assign altSel = regs[REG_ALT];
  assign pinOut = battFault ? regs[REG_BFOUT]
                : (sleepMode ? regs[REG_SOUT] : regs[REG_OUT]);

  // R9: without a clear write, no status bit falls
  a_r9_sticky_status: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn[REG_STAT] |=> ((status & $past(status)) == $past(status)));

  // R10: the combined line needs some recorded event behind it
  a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (status != '0));

  // R4: output enables move only on a direction write
  a_r4_oe_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn[REG_DIR] |=> $stable(pinOe));

  // R3: the read-only level view never takes bus data
  a_r3_level_from_pins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (syncB == $past(syncA)));

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [PINS-1:0]   regWdata,
  output logic [PINS-1:0]   regRdata,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  output logic [PINS-1:0]   altSel,
  input  logic              sleepMode,
  input  logic              battFault,
  output logic              irqOut
);

  strobe_t strb;

  gpio_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  gpio_bank_dp #(.PINS(PINS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWdata  (regWdata),
    .regRdata  (regRdata),
    .pinIn     (pinIn),
    .pinOut    (pinOut),
    .pinOe     (pinOe),
    .altSel    (altSel),
    .sleepMode (sleepMode),
    .battFault (battFault),
    .irqOut    (irqOut)
  );

endmodule

// File: tb/gpio_irq_bank_tb.sv
module gpio_irq_bank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic [15:0] pinIn = 16'hFFFF;
  logic [15:0] pinOut, pinOe, altSel;
  logic        sleepMode = 1'b0;
  logic        battFault = 1'b0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .altSel(altSel),
    .sleepMode(sleepMode), .battFault(battFault), .irqOut(irqOut)
  );

  typedef struct packed {
    logic [5:0]  addr;
    logic [15:0] wdat;
    logic [15:0] expd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{6'h00, 16'hA5A5, 16'hA5A5},
    '{6'h04, 16'h00FF, 16'h00FF},
    '{6'h08, 16'h1234, 16'h1234},
    '{6'h0C, 16'h0000, 16'h0000},
    '{6'h10, 16'hF0F0, 16'hF0F0},
    '{6'h18, 16'h5A5A, 16'h5A5A},
    '{6'h1C, 16'h8001, 16'h8001},
    '{6'h20, 16'h7FFE, 16'h7FFE},
    '{6'h28, 16'h0F0F, 16'h0F0F},
    '{6'h2C, 16'h0003, 16'h0003},
    '{6'h30, 16'h0000, 16'hFFFF},
    '{6'h34, 16'h1111, 16'h0000},
    '{6'h3C, 16'h2222, 16'h0000},
    '{6'h2A, 16'h3333, 16'h0000}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  logic [15:0] v;

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R1: state under reset
    rd(6'h00, v); chk("R1 mask in reset", v, 16'h0);
    rd(6'h24, v); chk("R1 status in reset", v, 16'h0);
    rd(6'h30, v); chk("R1 level view in reset", v, 16'h0);
    chk("R1 oe", pinOe, 16'h0);
    chk("R1 out", pinOut, 16'h0);
    chk("R1 alt", altSel, 16'h0);
    chk("R1 irq", {15'h0, irqOut}, 16'h0);
    rstN = 1'b1;
    idle(4);
    wr(6'h24, 16'hFFFF);
    rd(6'h24, v); chk("R9 clear after reset", v, 16'h0);
    chk("R10 irq idle", {15'h0, irqOut}, 16'h0);

    // R2 / R3: table walk of write then read-back
    for (int k = 0; k < NV; k++) begin
      wr(VECS[k].addr, VECS[k].wdat);
      rd(VECS[k].addr, v);
      chk("R2 R3 register readback", v, VECS[k].expd);
    end

    // R4, R12
    chk("R4 oe", pinOe, 16'h00FF);
    chk("R4 normal out", pinOut, 16'h1234);
    chk("R12 alt select", altSel, 16'h0F0F);
    // R5, R6
    sleepMode = 1'b1; #1 chk("R5 sleep out", pinOut, 16'h8001);
    battFault = 1'b1; #1 chk("R6 fault over sleep", pinOut, 16'h7FFE);
    sleepMode = 1'b0; #1 chk("R6 fault alone", pinOut, 16'h7FFE);
    battFault = 1'b0; #1 chk("R4 back to normal", pinOut, 16'h1234);

    wr(6'h00, 16'h0); wr(6'h18, 16'h0); wr(6'h10, 16'h0); wr(6'h0C, 16'h0);
    wr(6'h24, 16'hFFFF);
    rd(6'h24, v); chk("R7 quiet with pins high", v, 16'h0);

    // R7: high-level detect on pin 0, clear while level persists
    wr(6'h14, 16'h0001);
    idle(2);
    rd(6'h24, v); chk("R7 high level sets", v, 16'h0001);
    chk("R10 irq on", {15'h0, irqOut}, 16'h1);
    wr(6'h24, 16'h0001);
    rd(6'h24, v); chk("R7 R9 level re-sets after clear", v, 16'h0001);
    @(negedge clk); pinIn[0] = 1'b0;
    idle(4);
    wr(6'h24, 16'h0001);
    rd(6'h24, v); chk("R7 cleared once level gone", v, 16'h0);
    chk("R10 irq off", {15'h0, irqOut}, 16'h0);

    // R10: mask blocks line, not status
    wr(6'h00, 16'h0002);
    wr(6'h14, 16'h0003);
    idle(2);
    rd(6'h24, v); chk("R10 masked pin still records", v, 16'h0002);
    chk("R10 masked irq", {15'h0, irqOut}, 16'h0);
    wr(6'h00, 16'h0000);
    chk("R10 unmasked irq", {15'h0, irqOut}, 16'h1);
    // R11: sleep mask only in sleep
    wr(6'h18, 16'h0002);
    chk("R11 sleep mask idle when awake", {15'h0, irqOut}, 16'h1);
    sleepMode = 1'b1; #1
    chk("R11 sleep mask gates", {15'h0, irqOut}, 16'h0);
    sleepMode = 1'b0;
    wr(6'h14, 16'h0001);
    idle(1);
    wr(6'h24, 16'h0002);
    rd(6'h24, v); chk("R9 clear pin1", v, 16'h0);

    // R8: rising edge on pin 2
    wr(6'h10, 16'h0004);
    wr(6'h0C, 16'h0004);
    @(negedge clk); pinIn[2] = 1'b0;
    idle(4);
    rd(6'h24, v); chk("R8 falling ignored when rising armed", v, 16'h0);
    pinIn[2] = 1'b1;
    idle(4);
    rd(6'h24, v); chk("R8 rising sets", v, 16'h0004);
    wr(6'h24, 16'h0004);
    idle(3);
    rd(6'h24, v); chk("R8 edge not re-armed by level", v, 16'h0);
    // R8: falling edge on pin 3
    wr(6'h0C, 16'h000C);
    pinIn[3] = 1'b0;
    idle(4);
    rd(6'h24, v); chk("R8 falling sets", v, 16'h0008);
    wr(6'h24, 16'h0004);
    rd(6'h24, v); chk("R9 zero bits leave status", v, 16'h0008);
    chk("R10 irq from edge", {15'h0, irqOut}, 16'h1);

    // R3: synchroniser latency, edge by edge
    regAddr = 6'h30;
    pinIn[5] = 1'b0;
    @(negedge clk); #1 chk("R3 one edge later unchanged", regRdata, 16'hFFF6);
    @(negedge clk); #1 chk("R3 two edges later updated", regRdata, 16'hFFD6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule